// File: doc/BRIEF.md
# Lockable Bark/Bite Watchdog Timer

This block is a watchdog built around a single up-counter that is compared against two programmable limits. When the count reaches the first limit (the bark limit), an interrupt status bit is set so that software gets a warning. When it reaches the second limit (the bite limit), a reset request is raised and held. Software keeps the system alive by writing the count register, and writing zero restarts the count.

A control register holds a run bit and a pause-while-asleep bit. When pausing is selected, a high `sleep` input freezes the count. A configuration-unlock bit reads 1 after reset. Writing a one to that bit clears it for good. From then on the control and limit registers ignore writes until the next reset. Count writes are still accepted while locked, so a locked watchdog can still be serviced. The register port is a simple single-cycle write strobe with a combinational read port.

Top module: `bark_bite_wdog`

## Requirements
- R1: After reset the count is 0, the control bits are 0, both limits are all ones, the unlock bit reads 1, the bark status is 0 and `bite_req` is 0.
- R2: While the run bit (control bit 0) is 1, the count rises by one on each clock and holds at all ones. While the run bit is 0, the count holds.
- R3: While the pause bit (control bit 1) is 1 and `sleep` is 1, the count holds. If `sleep` is 1 but the pause bit is 0, counting continues.
- R4: On each clock where the run bit is 1 and count >= bark limit, the bark status bit is set on that edge. `bark_irq` shows this bit.
- R5: Writing to the interrupt status word (address 5) with bit 0 set clears the bark status bit. A write with bit 0 clear has no effect. If a set condition occurs on the same edge, the set wins.
- R6: Writing to the interrupt test word (address 6) with bit 0 set sets the bark status bit. Bit 0 is the bark position in both the status and the test words. The test word reads 0.
- R7: On each clock where the run bit is 1 and count >= bite limit, `bite_req` is set on that edge. It stays high until a count write or a reset.
- R8: A write to the count register (address 4) loads the written value, so writing 0 pets the watchdog. It clears `bite_req`, takes priority over counting, and is accepted while locked.
- R9: The unlock bit (address 1, bit 0) reads 1 after reset. Writing it with bit 0 set clears it. Writing bit 0 clear has no effect. Only reset sets it again.
- R10: While the unlock bit is 0, writes to control (address 0), bark limit (address 2) and bite limit (address 3) leave those registers unchanged.
- R11: Reads at addresses 0 to 5 return control, unlock, bark limit, bite limit, count and bark status. Addresses 6 and 7 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_addr | input | 3 | Write word address |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read word address |
| rd_data | output | CNT_W | Read data, combinational from rd_addr |
| sleep | input | 1 | Low-power state indication |
| bark_irq | output | 1 | Bark interrupt, level of the status bit |
| bite_req | output | 1 | Held reset request |

## Verification
The assertions assume that `wr_en`, `wr_addr`, `wr_data` and `sleep` are synchronous to `clk`, free of X, and settled before each rising edge. They also assume that a write is a one-cycle strobe. The bench drives every input on the falling edge and samples on the next falling edge, which keeps the stimulus inside those limits. Reset is raised and released away from the rising edge, so the internal synchronizer sees a clean release.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef enum logic [2:0] {
    ADR_CTRL   = 3'd0,
    ADR_UNLOCK = 3'd1,
    ADR_BARK   = 3'd2,
    ADR_BITE   = 3'd3,
    ADR_COUNT  = 3'd4,
    ADR_ISTAT  = 3'd5,
    ADR_ITEST  = 3'd6
  } wdog_addr_e;

  localparam int unsigned ADDR_W    = 3;
  localparam int unsigned BIT_RUN   = 0;
  localparam int unsigned BIT_PAUSE = 1;
  localparam int unsigned BIT_KEY   = 0;
  // bark position shared by the status and test words
  localparam int unsigned BIT_BARK  = 0;

endpackage

// File: rtl/wdog_rst_sync.sv
module wdog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];

endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [CNT_W-1:0]     wr_data,
  output logic                 run_o,
  output logic                 pause_o,
  output logic [CNT_W-1:0]     bark_lim_o,
  output logic [CNT_W-1:0]     bite_lim_o,
  output logic                 unlocked_o
);

  logic             run_q, run_d;
  logic             pause_q, pause_d;
  logic [CNT_W-1:0] bark_q, bark_d;
  logic [CNT_W-1:0] bite_q, bite_d;
  logic             key_q, key_d;
  logic             cfg_we;

  assign cfg_we = wr_en & key_q;

  always_comb begin
    run_d   = run_q;
    pause_d = pause_q;
    bark_d  = bark_q;
    bite_d  = bite_q;
    key_d   = key_q;
    if (cfg_we && wr_addr == ADR_CTRL) begin
      run_d   = wr_data[BIT_RUN];
      pause_d = wr_data[BIT_PAUSE];
    end
    if (cfg_we && wr_addr == ADR_BARK) bark_d = wr_data;
    if (cfg_we && wr_addr == ADR_BITE) bite_d = wr_data;
    if (wr_en && wr_addr == ADR_UNLOCK && wr_data[BIT_KEY]) key_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      pause_q <= 1'b0;
      bark_q  <= '1;
      bite_q  <= '1;
      key_q   <= 1'b1;
    end else begin
      run_q   <= run_d;
      pause_q <= pause_d;
      bark_q  <= bark_d;
      bite_q  <= bite_d;
      key_q   <= key_d;
    end
  end

  assign run_o      = run_q;
  assign pause_o    = pause_q;
  assign bark_lim_o = bark_q;
  assign bite_lim_o = bite_q;
  assign unlocked_o = key_q;

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)                         cnt_d = load_val_i;
    else if (step_i && cnt_q != CNT_MAX) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/wdog_alarm.sv
module wdog_alarm #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] bark_lim_i,
  input  logic [CNT_W-1:0] bite_lim_i,
  input  logic             irq_clr_i,
  input  logic             irq_force_i,
  input  logic             pet_i,
  output logic             bark_o,
  output logic             bite_o
);

  logic bark_q, bark_d;
  logic bite_q, bite_d;
  logic bark_hit, bite_hit;

  assign bark_hit = run_i && (count_i >= bark_lim_i);
  assign bite_hit = run_i && (count_i >= bite_lim_i);

  always_comb begin
    bark_d = bark_q;
    if (irq_clr_i)               bark_d = 1'b0;
    if (irq_force_i || bark_hit) bark_d = 1'b1;
    bite_d = bite_q;
    if (bite_hit) bite_d = 1'b1;
    if (pet_i)    bite_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bark_q <= 1'b0;
      bite_q <= 1'b0;
    end else begin
      bark_q <= bark_d;
      bite_q <= bite_d;
    end
  end

  assign bark_o = bark_q;
  assign bite_o = bite_q;

endmodule

// File: rtl/bark_bite_wdog.sv
module bark_bite_wdog
  import wdog_pkg::*;
#(
  parameter int unsigned CNT_W     = 32,
  parameter int unsigned SYNC_STGS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [2:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  input  logic             sleep,
  output logic             bark_irq,
  output logic             bite_req
);

  logic             rst_sync_n;
  logic             ctrl_run, ctrl_pause, unlocked;
  logic [CNT_W-1:0] bark_lim, bite_lim, count_q;
  logic             cnt_wr, irq_clr, irq_force, step;

  wdog_rst_sync #(.STAGES(SYNC_STGS)) u_rst (
    .clk(clk), .arst_n(rst_n), .rst_n_o(rst_sync_n)
  );

  wdog_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .run_o(ctrl_run), .pause_o(ctrl_pause),
    .bark_lim_o(bark_lim), .bite_lim_o(bite_lim), .unlocked_o(unlocked)
  );

  assign cnt_wr    = wr_en && (wr_addr == ADR_COUNT);
  assign irq_clr   = wr_en && (wr_addr == ADR_ISTAT) && wr_data[BIT_BARK];
  assign irq_force = wr_en && (wr_addr == ADR_ITEST) && wr_data[BIT_BARK];
  assign step      = ctrl_run && !(ctrl_pause && sleep);

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .step_i(step), .load_i(cnt_wr),
    .load_val_i(wr_data), .count_o(count_q)
  );

  wdog_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk(clk), .rst_n(rst_sync_n), .run_i(ctrl_run), .count_i(count_q),
    .bark_lim_i(bark_lim), .bite_lim_i(bite_lim), .irq_clr_i(irq_clr),
    .irq_force_i(irq_force), .pet_i(cnt_wr), .bark_o(bark_irq),
    .bite_o(bite_req)
  );

  always_comb begin
    rd_data = '0;
    unique case (rd_addr)
      ADR_CTRL: begin
        rd_data[BIT_RUN]   = ctrl_run;
        rd_data[BIT_PAUSE] = ctrl_pause;
      end
      ADR_UNLOCK: rd_data[BIT_KEY]  = unlocked;
      ADR_BARK:   rd_data           = bark_lim;
      ADR_BITE:   rd_data           = bite_lim;
      ADR_COUNT:  rd_data           = count_q;
      ADR_ISTAT:  rd_data[BIT_BARK] = bark_irq;
      default:    rd_data           = '0;
    endcase
  end

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
  parameter int unsigned CNT_W = 32
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             wr_en,
  input logic [2:0]       wr_addr,
  input logic [CNT_W-1:0] wr_data,
  input logic             sleep,
  input logic             ctrl_run,
  input logic             ctrl_pause,
  input logic             unlocked,
  input logic [CNT_W-1:0] count_q,
  input logic             bark_irq,
  input logic             bite_req
);

  logic cnt_wr;
  assign cnt_wr = wr_en && (wr_addr == 3'd4);

  // R2
  a_r2_count_step: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_run && !(ctrl_pause && sleep) && !cnt_wr && count_q != '1)
    |=> count_q == $past(count_q) + 1'b1);

  // R3
  a_r3_sleep_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ctrl_pause && sleep && !cnt_wr) |=> $stable(count_q));

  // R8
  a_r8_count_load: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cnt_wr |=> (count_q == $past(wr_data)) && !bite_req);

  // R7
  a_r7_bite_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bite_req && !cnt_wr) |=> bite_req);

  // R5
  a_r5_bark_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bark_irq && !(wr_en && wr_addr == 3'd5 && wr_data[0])) |=> bark_irq);

  // R9
  a_r9_lock_oneway: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !unlocked |=> !unlocked);

  // R10
  a_r10_ctrl_frozen: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !unlocked |=> $stable(ctrl_run) && $stable(ctrl_pause));

endmodule

bind bark_bite_wdog wdog_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .sleep(sleep), .ctrl_run(ctrl_run),
  .ctrl_pause(ctrl_pause), .unlocked(unlocked), .count_q(count_q),
  .bark_irq(bark_irq), .bite_req(bite_req)
);

// File: tb/tb_bark_bite_wdog.sv
module tb_bark_bite_wdog;

  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         wr_en;
  logic [2:0]   wr_addr;
  logic [W-1:0] wr_data;
  logic [2:0]   rd_addr;
  logic [W-1:0] rd_data;
  logic         sleep;
  logic         bark_irq;
  logic         bite_req;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bark_bite_wdog #(.CNT_W(W)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .sleep(sleep), .bark_irq(bark_irq), .bite_req(bite_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [2:0] a, input int exp);
    rd_addr = a;
    #1;
    chk(req, int'(rd_data), exp);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic prep();
    wr(3'd0, 8'h00);
    wr(3'd4, 8'h00);
    wr(3'd5, 8'h01);
  endtask

  initial begin
    wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0; sleep = 0;
    do_reset();

    // R1 reset state, R11 address map
    rd_chk("R1 ctrl", 3'd0, 0);
    rd_chk("R1 unlock", 3'd1, 1);
    rd_chk("R1 bark limit", 3'd2, 8'hFF);
    rd_chk("R1 bite limit", 3'd3, 8'hFF);
    rd_chk("R1 count", 3'd4, 0);
    rd_chk("R1 status", 3'd5, 0);
    rd_chk("R11 test word reads 0", 3'd6, 0);
    rd_chk("R11 addr 7 reads 0", 3'd7, 0);
    chk("R1 bark_irq", int'(bark_irq), 0);
    chk("R1 bite_req", int'(bite_req), 0);

    // R4 / R7 / R2 sweep of bark and bite limits
    for (int b = 0; b < 8; b++) begin
      prep();
      wr(3'd2, W'(b));
      wr(3'd3, W'(b + 3));
      wr(3'd0, 8'h01);
      for (int k = 1; k <= 14; k++) begin
        @(negedge clk);
        rd_chk("R2 count", 3'd4, k);
        chk("R4 bark", int'(bark_irq), int'(k >= b + 1));
        rd_chk("R4 status word", 3'd5, int'(k >= b + 1));
        chk("R7 bite", int'(bite_req), int'(k >= b + 4));
      end
    end

    // R7 bite held after stop, cleared by count write (R8)
    wr(3'd0, 8'h00);
    repeat (3) @(negedge clk);
    chk("R7 bite held", int'(bite_req), 1);
    wr(3'd4, 8'h00);
    chk("R8 pet clears bite", int'(bite_req), 0);
    rd_chk("R8 pet count", 3'd4, 0);

    // R5 W1C on bark status
    chk("R5 bark still set", int'(bark_irq), 1);
    wr(3'd5, 8'h00);
    chk("R5 write 0 ignored", int'(bark_irq), 1);
    wr(3'd5, 8'h01);
    chk("R5 write 1 clears", int'(bark_irq), 0);
    wr(3'd2, 8'h00);
    wr(3'd3, 8'hFF);
    wr(3'd0, 8'h01);
    @(negedge clk);
    chk("R4 bark at limit 0", int'(bark_irq), 1);
    wr(3'd5, 8'h01);
    chk("R5 set wins over clear", int'(bark_irq), 1);
    wr(3'd0, 8'h00);
    wr(3'd5, 8'h01);
    chk("R5 clear when idle", int'(bark_irq), 0);

    // R6 test word
    wr(3'd6, 8'h00);
    chk("R6 test write 0", int'(bark_irq), 0);
    wr(3'd6, 8'h01);
    chk("R6 test sets bark", int'(bark_irq), 1);
    rd_chk("R6 status bit 0", 3'd5, 1);
    rd_chk("R6 test word reads 0", 3'd6, 0);
    wr(3'd5, 8'h01);

    // R3 pause/sleep combinations
    wr(3'd2, 8'hFF);
    for (int p = 0; p < 2; p++) begin
      for (int s = 0; s < 2; s++) begin
        prep();
        sleep = s[0];
        wr(3'd0, {6'b0, p[0], 1'b1});
        repeat (5) @(negedge clk);
        rd_chk("R3 pause/sleep count", 3'd4, (p == 1 && s == 1) ? 0 : 5);
      end
    end
    sleep = 1'b0;

    // R2 stopped holds, saturation
    prep();
    repeat (5) @(negedge clk);
    rd_chk("R2 stopped holds", 3'd4, 0);
    wr(3'd4, 8'hFD);
    wr(3'd0, 8'h01);
    rd_chk("R2 sat start", 3'd4, 8'hFD);
    @(negedge clk); rd_chk("R2 sat step", 3'd4, 8'hFE);
    @(negedge clk); rd_chk("R2 sat top", 3'd4, 8'hFF);
    @(negedge clk); rd_chk("R2 sat hold", 3'd4, 8'hFF);

    // R8 load beats increment
    wr(3'd4, 8'h10);
    rd_chk("R8 load priority", 3'd4, 8'h10);
    @(negedge clk);
    rd_chk("R8 count after load", 3'd4, 8'h11);

    // R9 / R10 lock
    wr(3'd0, 8'h00);
    wr(3'd2, 8'h20);
    wr(3'd3, 8'h30);
    wr(3'd0, 8'h02);
    wr(3'd1, 8'h00);
    rd_chk("R9 write 0 keeps unlocked", 3'd1, 1);
    wr(3'd1, 8'h01);
    rd_chk("R9 write 1 locks", 3'd1, 0);
    wr(3'd0, 8'h01);
    rd_chk("R10 ctrl frozen", 3'd0, 2);
    wr(3'd2, 8'h05);
    rd_chk("R10 bark frozen", 3'd2, 8'h20);
    wr(3'd3, 8'h05);
    rd_chk("R10 bite frozen", 3'd3, 8'h30);
    wr(3'd1, 8'h00);
    rd_chk("R9 cannot unlock", 3'd1, 0);
    wr(3'd4, 8'h42);
    rd_chk("R8 count write while locked", 3'd4, 8'h42);
    do_reset();
    rd_chk("R9 reset unlocks", 3'd1, 1);
    rd_chk("R1 ctrl after reset", 3'd0, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule